// File: doc/BRIEF.md
# Per-Channel Burst Ceiling Selector

This block sits beside the scheduler of an egress packet interface that carries 64 logical channels. Every channel owns a small descriptor. The descriptor holds two 4-bit ceiling codes and a 2-bit route code. The receiver reports a credit state for each channel: satisfied, hungry or starving. The block takes the state of the channel that the scheduler selects and picks the matching ceiling code. It turns that code into a byte limit of (code+1)×16, so the limit ranges from 16 to 256 bytes.

The ceiling applies only to channels whose route code points at the egress interface. Channels routed elsewhere, and satisfied channels, get a limit of zero. The route code of the selected channel is always presented so that downstream logic can steer the traffic. Software writes descriptors through a simple register port and can read them back at any time. If a write leaves the starving ceiling below the hungry ceiling, the block still stores it but sets a sticky error flag.

Top module: `burst_ceiling_ctl`

## Requirements
- R1: After reset every descriptor reads 0x0000_03FF (both ceiling codes 0xF, route code 3). The burst limit output is 0, the route output is 3 and the error flag is 0.
- R2: A write stores bits 9:0 of the write data into the addressed descriptor. The hungry code is in bits 3:0, the starving code in bits 7:4 and the route code in bits 9:8. A read returns those bits with bits 31:10 as zero, in the same cycle as the address is presented.
- R3: Take a selected channel whose route code is 00 and whose state code is 01 (hungry). One clock edge later, the limit is (hungry code+1)×16 bytes.
- R4: Take a selected channel whose route code is 00 and whose state code is 10 (starving). One clock edge later, the limit is (starving code+1)×16 bytes.
- R5: State code 00 (satisfied) and the unused code 11 both give a limit of 0.
- R6: A route code other than 00 (01 secondary port, 10 management capture, 11 discard) gives a limit of 0, whatever the state.
- R7: The route output equals the selected channel's route code one clock edge after selection. It uses the descriptor as it stood before a write at that same edge.
- R8: A write whose bits 7:4 are below its bits 3:0 sets the error flag. The flag stays set until reset, and the write is still stored unchanged.
- R9: Only the 2-bit state field of the selected channel (bits 2c+1:2c for channel c) affects the result. The states of all other channels are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_state | input | 128 | Per-channel credit state, 2 bits per channel |
| sel_ch | input | 6 | Channel being scheduled |
| cfg_wr_en | input | 1 | Descriptor write strobe |
| cfg_wr_addr | input | 6 | Descriptor written |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_addr | input | 6 | Descriptor read |
| cfg_rd_data | output | 32 | Read data, combinational |
| burst_bytes | output | 9 | Permitted burst in bytes, registered |
| route_out | output | 2 | Route code of selected channel, registered |
| cfg_err | output | 1 | Sticky ceiling-order error |

## Verification
The bench aims at the ends of the ceiling range: code 0 must give 16 bytes and code 0xF must give 256. A design that forgets the +1 or truncates the sum to 8 bits returns 0 instead. It also writes the channel that is selected in that same cycle. A design that forwards the new descriptor shows the new limit one cycle early. Routes other than 00 combined with a starving state expose a design that ignores the route gate. Busy neighbouring channel states expose a wrong part-select. A bad write followed by a good one shows a flag that is not sticky, or a write that was dropped instead of stored.

// File: rtl/bcl_pkg.sv
// Shared types for the burst ceiling selector.
// Assumes fixed 4-bit ceiling codes and a 2-bit route code per descriptor.
package bcl_pkg;
    localparam int CODE_W  = 4;
    localparam int ROUTE_W = 2;
    localparam int DESC_W  = 2 * CODE_W + ROUTE_W;

    typedef enum logic [1:0] {
        ST_SATISFIED = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_STARVING  = 2'b10,
        ST_UNUSED    = 2'b11
    } link_state_e;

    localparam logic [ROUTE_W-1:0] ROUTE_EGRESS  = 2'b00;
    localparam logic [ROUTE_W-1:0] ROUTE_DISCARD = 2'b11;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic [CODE_W-1:0]  lim_s;
        logic [CODE_W-1:0]  lim_h;
    } chan_desc_t;

    localparam chan_desc_t DESC_RST = '{route: ROUTE_DISCARD, lim_s: 4'hF, lim_h: 4'hF};
endpackage

// File: rtl/bcl_desc_store.sv
// Descriptor storage: one flop word per channel, a write port, a
// combinational read port for software, a lookup port for the selected
// channel, and a sticky flag for writes with starving < hungry.
// Assumes at most one write per cycle; reserved write bits are dropped.
module bcl_desc_store
    import bcl_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    input  logic [IDX_W-1:0]  look_idx,
    output chan_desc_t        look_desc,
    output logic              order_err
);
    chan_desc_t store [NUM_CH];
    chan_desc_t wr_desc;

    assign wr_desc = chan_desc_t'(wr_word[DESC_W-1:0]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Hold one channel's descriptor, replaced on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= DESC_RST;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                store[g] <= wr_desc;
        end
    end

    // Latch the ordering error until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            order_err <= 1'b0;
        else if (wr_en && (wr_desc.lim_s < wr_desc.lim_h))
            order_err <= 1'b1;
    end

    // Present the software view with reserved bits as zero.
    always_comb begin
        rd_word = '0;
        rd_word[DESC_W-1:0] = store[rd_idx];
    end

    assign look_desc = store[look_idx];
endmodule

// File: rtl/bcl_ceiling_calc.sv
// Turns a descriptor and a credit state into a byte ceiling.
// Assumes the ceiling is (code+1)*STEP_BYTES and is gated by the egress route.
module bcl_ceiling_calc
    import bcl_pkg::*;
#(
    parameter int STEP_BYTES = 16,
    parameter int BURST_W    = 9
) (
    input  chan_desc_t         desc,
    input  link_state_e        state,
    output logic [BURST_W-1:0] ceiling
);
    // Choose the code by state, scale it, and zero it when not allowed.
    always_comb begin
        ceiling = '0;
        if (desc.route == ROUTE_EGRESS) begin
            unique case (state)
                ST_HUNGRY:   ceiling = BURST_W'((int'(desc.lim_h) + 1) * STEP_BYTES);
                ST_STARVING: ceiling = BURST_W'((int'(desc.lim_s) + 1) * STEP_BYTES);
                default:     ceiling = '0;
            endcase
        end
    end
endmodule

// File: rtl/burst_ceiling_ctl.sv
// Top: selects the scheduled channel's state and descriptor, computes the
// burst ceiling and route, and registers both. Assumes ch_state is stable
// around the sampling edge; a write at the same edge affects the next cycle.
module burst_ceiling_ctl
    import bcl_pkg::*;
#(
    parameter int NUM_CH     = 64,
    parameter int STEP_BYTES = 16,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = $clog2(NUM_CH),
    localparam int BURST_W   = $clog2((1 << CODE_W) * STEP_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NUM_CH-1:0] ch_state,
    input  logic [IDX_W-1:0]    sel_ch,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_wr_addr,
    input  logic [DATA_W-1:0]   cfg_wr_data,
    input  logic [IDX_W-1:0]    cfg_rd_addr,
    output logic [DATA_W-1:0]   cfg_rd_data,
    output logic [BURST_W-1:0]  burst_bytes,
    output logic [ROUTE_W-1:0]  route_out,
    output logic                cfg_err
);
    chan_desc_t         sel_desc;
    link_state_e        sel_state;
    logic [BURST_W-1:0] ceiling_d;

    bcl_desc_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_idx    (cfg_wr_addr),
        .wr_word   (cfg_wr_data),
        .rd_idx    (cfg_rd_addr),
        .rd_word   (cfg_rd_data),
        .look_idx  (sel_ch),
        .look_desc (sel_desc),
        .order_err (cfg_err)
    );

    // Pick the 2-bit state field of the scheduled channel.
    assign sel_state = link_state_e'(ch_state[{sel_ch, 1'b0} +: 2]);

    bcl_ceiling_calc #(.STEP_BYTES(STEP_BYTES), .BURST_W(BURST_W)) u_calc (
        .desc    (sel_desc),
        .state   (sel_state),
        .ceiling (ceiling_d)
    );

    // Register the decision for the scheduler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_bytes <= '0;
            route_out   <= ROUTE_DISCARD;
        end else begin
            burst_bytes <= ceiling_d;
            route_out   <= sel_desc.route;
        end
    end
endmodule

// File: rtl/bcl_checker.sv
// Port-level properties of burst_ceiling_ctl, bound to every instance.
// Assumes the state encoding and write field layout of bcl_pkg.
module bcl_checker
    import bcl_pkg::*;
#(
    parameter int NUM_CH     = 64,
    parameter int STEP_BYTES = 16,
    parameter int DATA_W     = 32,
    parameter int BURST_W    = 9,
    localparam int IDX_W     = $clog2(NUM_CH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_CH-1:0] ch_state,
    input logic [IDX_W-1:0]    sel_ch,
    input logic                cfg_wr_en,
    input logic [DATA_W-1:0]   cfg_wr_data,
    input logic [BURST_W-1:0]  burst_bytes,
    input logic [ROUTE_W-1:0]  route_out,
    input logic                cfg_err
);
    logic [1:0] cur_state;
    assign cur_state = ch_state[{sel_ch, 1'b0} +: 2];

    assert_ceiling_grid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((burst_bytes % STEP_BYTES) == 0) && (int'(burst_bytes) <= 16 * STEP_BYTES));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == 2'b00 || cur_state == 2'b11) |=> (burst_bytes == '0));

    assert_route_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_bytes != '0) |-> (route_out == ROUTE_EGRESS));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_err_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && (cfg_wr_data[7:4] < cfg_wr_data[3:0])) |=> cfg_err);
endmodule

bind burst_ceiling_ctl bcl_checker #(
    .NUM_CH(NUM_CH), .STEP_BYTES(STEP_BYTES), .DATA_W(DATA_W), .BURST_W(BURST_W)
) u_bcl_checker (
    .clk(clk), .rst_n(rst_n), .ch_state(ch_state), .sel_ch(sel_ch),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .burst_bytes(burst_bytes), .route_out(route_out), .cfg_err(cfg_err)
);

// File: tb/tb_burst_ceiling_ctl.sv
// Bench: behavioural reference model updated at each rising edge, outputs
// compared at every falling edge, plus directed register read checks.
module tb_burst_ceiling_ctl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] ch_state = '0;
    logic [5:0]   sel_ch = '0;
    logic         cfg_wr_en = 1'b0;
    logic [5:0]   cfg_wr_addr = '0;
    logic [31:0]  cfg_wr_data = '0;
    logic [5:0]   cfg_rd_addr = '0;
    logic [31:0]  cfg_rd_data;
    logic [8:0]   burst_bytes;
    logic [1:0]   route_out;
    logic         cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_desc [64];
    int m_err = 0;
    int exp_burst = 0;
    int exp_route = 3;

    always #4 clk = ~clk;

    burst_ceiling_ctl dut (
        .clk(clk), .rst_n(rst_n), .ch_state(ch_state), .sel_ch(sel_ch),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .burst_bytes(burst_bytes), .route_out(route_out), .cfg_err(cfg_err)
    );

    // Reference model: decision from pre-edge descriptors, then apply write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_desc[i] = 'h3FF;
            m_err = 0; exp_burst = 0; exp_route = 3;
        end else begin
            int d, st, h, s;
            d  = m_desc[sel_ch];
            st = int'(ch_state[2*sel_ch +: 2]);
            h  = d & 15; s = (d >> 4) & 15;
            exp_route = (d >> 8) & 3;
            if (exp_route != 0) exp_burst = 0;
            else if (st == 1) exp_burst = (h + 1) * 16;
            else if (st == 2) exp_burst = (s + 1) * 16;
            else exp_burst = 0;
            if (cfg_wr_en) begin
                m_desc[cfg_wr_addr] = int'(cfg_wr_data[9:0]);
                if (cfg_wr_data[7:4] < cfg_wr_data[3:0]) m_err = 1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every cycle after the edge has settled.
    always @(negedge clk) begin
        if (!done) begin
            chk("R3 R4 R5 R6 burst", int'(burst_bytes), exp_burst);
            chk("R7 route", int'(route_out), exp_route);
            chk("R8 cfg_err", int'(cfg_err), m_err);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wr(int idx, logic [31:0] val);
        cfg_wr_en = 1'b1; cfg_wr_addr = 6'(idx); cfg_wr_data = val;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, int idx);
        cfg_rd_addr = 6'(idx); #1;
        chk(req, int'(cfg_rd_data), m_desc[idx]);
    endtask

    task automatic set_state(int ch, logic [1:0] st);
        ch_state[2*ch +: 2] = st;
    endtask

    task automatic look(int ch, logic [1:0] st);
        sel_ch = 6'(ch); set_state(ch, st);
        tick();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 burst", int'(burst_bytes), 0);
        chk("R1 route", int'(route_out), 3);
        rd_chk("R1 reset desc", 0);
        rd_chk("R1 reset desc", 63);
        chk("R1 reset value", int'(cfg_rd_data), 'h3FF);
        rst_n = 1'b1;
        look(0, 2'b10);          // default route 3 -> zero (R6)
        tick();
        // R2 R3 R4 R5: basic ceilings
        wr(5, 32'h073);
        rd_chk("R2 readback", 5);
        look(5, 2'b01); tick(); chk("R3 hungry 64", int'(burst_bytes), 64);
        look(5, 2'b10); tick(); chk("R4 starving 128", int'(burst_bytes), 128);
        look(5, 2'b00); tick(); chk("R5 satisfied", int'(burst_bytes), 0);
        look(5, 2'b11); tick(); chk("R5 unused code", int'(burst_bytes), 0);
        // R9: neighbours busy, selected hungry
        ch_state = {64{2'b10}};
        set_state(5, 2'b01); tick(); tick();
        chk("R9 neighbours ignored", int'(burst_bytes), 64);
        set_state(5, 2'b00); set_state(4, 2'b01); set_state(6, 2'b01); tick(); tick();
        chk("R9 neighbours ignored", int'(burst_bytes), 0);
        // R6 R7: other routes
        wr(9, 32'h1FF); look(9, 2'b10); tick(); chk("R6 route 1", int'(route_out), 1);
        wr(9, 32'h2FF); tick(); tick(); chk("R6 route 2", int'(burst_bytes), 0);
        wr(9, 32'h0FF); tick(); tick(); chk("R4 max 256", int'(burst_bytes), 256);
        wr(1, 32'h000); look(1, 2'b01); tick(); chk("R3 min 16", int'(burst_bytes), 16);
        // R7: write to the selected channel takes effect one cycle later
        sel_ch = 6'd1; set_state(1, 2'b10);
        cfg_wr_en = 1'b1; cfg_wr_addr = 6'd1; cfg_wr_data = 32'h300;
        tick(); cfg_wr_en = 1'b0;
        chk("R7 old descriptor", int'(burst_bytes), 16);
        tick();
        chk("R7 new descriptor", int'(route_out), 3);
        // R2: reserved bits dropped
        wr(12, 32'hFFFF_F0A5); rd_chk("R2 reserved zero", 12);
        chk("R2 value", int'(cfg_rd_data), 'h0A5);
        // R8: bad order stored, flag sticky
        wr(2, 32'h035); tick();
        chk("R8 flag set", int'(cfg_err), 1);
        rd_chk("R8 stored as given", 2);
        look(2, 2'b01); tick(); chk("R8 hungry 96", int'(burst_bytes), 96);
        wr(2, 32'h044); tick(); chk("R8 sticky", int'(cfg_err), 1);
        // Mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            cfg_wr_en = ($urandom_range(0, 3) == 0);
            cfg_wr_addr = 6'($urandom_range(0, 7));
            cfg_wr_data = {22'($urandom), 2'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                           8'($urandom)};
            sel_ch = 6'($urandom_range(0, 7));
            ch_state = {$urandom, $urandom, $urandom, $urandom};
            cfg_rd_addr = 6'($urandom_range(0, 63));
            #1; chk("R2 random read", int'(cfg_rd_data), m_desc[cfg_rd_addr]);
            tick();
        end
        cfg_wr_en = 1'b0;
        // R1: reset mid-run clears everything
        rst_n = 1'b0; tick(); tick();
        chk("R1 flag cleared", int'(cfg_err), 0);
        rd_chk("R1 desc restored", 5);
        rst_n = 1'b1; tick(); tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule